// File: doc/BRIEF.md
# Bit-band alias bridge

This bridge sits on a bus slave port and presents an alias window of 32 MB in which every 32-bit aligned word stands for a single bit of a 1 MB target region. A read of an alias word returns that target bit as 0 or 1. A write to an alias word sets or clears that one bit and leaves every other bit of the target untouched. Because the rest of the target is preserved, a program can change one flag without a read-modify-write sequence of its own.

Every alias access is turned into a target address and a bit position. A read becomes one master read. A write becomes a master read followed by a write-back of the same unit, and both phases are marked as locked on the master port. The slave port stalls until the whole sequence has finished. The target base is a parameter. A system normally places two copies of the bridge: one with target base 0x2000_0000 behind the alias window at 0x2200_0000, and one with target base 0x4000_0000 behind the window at 0x4200_0000. Window decoding is done upstream, so the bridge only looks at the low 25 offset bits.

Top module: `bitband_bridge`

## Requirements
- R1: The target byte address is TGT_BASE ORed with s_addr[24:0] shifted right by 5. Bits s_addr[31:25] and s_addr[1:0] have no effect on the access.
- R2: s_size selects the access unit: 0 is byte, 1 is halfword, and 2 or 3 is word. m_size carries the unit as 0, 1 or 2. A halfword clears bit 0 of the target address and a word clears bits 1:0. The bit index within the unit is s_addr[4:2] for a byte, s_addr[5:2] for a halfword and s_addr[6:2] for a word.
- R3: Master data lanes are little-endian. A byte at address A sits in bus bits 8*A[1:0]+7..8*A[1:0]. A halfword sits at 16*A[1]. Bit n of a word is bus bit n.
- R4: A read response carries the selected target bit in s_rdata[0], and s_rdata[31:1] is zero. A read issues exactly one master read (m_we=0) and no write.
- R5: A write reads the unit and then writes it back to the same address, with the selected bit replaced by s_wdata[0] and every other bit of the unit unchanged. s_wdata[31:1] is ignored. A write response has s_rdata equal to zero.
- R6: A write uses exactly two master phases, a read and then a write, to the same address in back-to-back requests. No other master access comes between them, and m_lock is high during both.
- R7: s_ready is a single-cycle pulse that marks completion. A master request stays asserted, with stable address, direction and write data, until m_ready.
- R8: If the read phase returns m_err, s_err is set, s_rdata is zero and no write-back is issued. If the write phase returns m_err, s_err is set. In both cases the target is not changed by the bridge.
- R9: Out of reset, s_ready, m_req and m_lock are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_req | input | 1 | Slave request, held until s_ready |
| s_we | input | 1 | Slave write (1) or read (0) |
| s_size | input | 2 | Access unit: 0 byte, 1 halfword, 2/3 word |
| s_addr | input | 32 | Alias address; low 25 bits are used |
| s_wdata | input | 32 | Write data; bit 0 is the new bit value |
| s_ready | output | 1 | One-cycle completion pulse |
| s_rdata | output | 32 | Read result, 0 or 1 |
| s_err | output | 1 | Error flag, valid with s_ready |
| m_req | output | 1 | Master request, held until m_ready |
| m_we | output | 1 | Master write (1) or read (0) |
| m_lock | output | 1 | Marks the locked read-modify-write sequence |
| m_size | output | 2 | Master unit: 0 byte, 1 halfword, 2 word |
| m_addr | output | 32 | Target byte address |
| m_wdata | output | 32 | Write-back data on little-endian lanes |
| m_ready | input | 1 | Master phase complete |
| m_rdata | input | 32 | Master read data on little-endian lanes |
| m_err | input | 1 | Master phase error, valid with m_ready |

## Verification
The bench builds two copies side by side: one with TGT_BASE 0x2000_0000 and one with 0x4000_0000, both with the 25-bit alias window. Both copies receive the same alias addresses, so one stimulus shows that the upper base bits pass straight into the target address while alias bits above bit 24 are dropped. Each copy has its own target memory model, whose response latency can be varied. The memory model can also fail a chosen word on its read or write phase, which brings the error paths and the locked two-phase sequence within reach at every unit size and lane position.

// File: rtl/bitband_pkg.sv
package bitband_pkg;

    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int POS_W  = $clog2(DATA_W);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } unit_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RD,
        ST_WR,
        ST_RSP
    } phase_e;

    typedef struct packed {
        phase_e              st;
        logic                we;
        logic                val;
        unit_e               unit;
        logic [ADDR_W-1:0]   addr;
        logic [POS_W-1:0]    pos;
        logic [DATA_W-1:0]   wword;
        logic                rbit;
        logic                err;
    } seq_regs_t;

endpackage

// File: rtl/bitband_addr_map.sv
module bitband_addr_map
    import bitband_pkg::*;
#(
    parameter logic [ADDR_W-1:0] TGT_BASE   = 32'h2000_0000,
    parameter int                ALIAS_BITS = 25
) (
    input  logic [ALIAS_BITS-1:2] alias_off,
    input  logic [1:0]            size_in,
    output unit_e                 unit_out,
    output logic [ADDR_W-1:0]     tgt_addr,
    output logic [POS_W-1:0]      bus_pos
);
    localparam int SHIFT = 5;

    logic [ADDR_W-1:0] raw;

    always_comb begin
        raw = TGT_BASE | ADDR_W'(alias_off[ALIAS_BITS-1:SHIFT]);
        unique case (size_in)
            2'd0: begin
                unit_out = SZ_BYTE;
                tgt_addr = raw;
                bus_pos  = {raw[1:0], alias_off[4:2]};
            end
            2'd1: begin
                unit_out = SZ_HALF;
                tgt_addr = {raw[ADDR_W-1:1], 1'b0};
                bus_pos  = {raw[1], alias_off[5:2]};
            end
            default: begin
                unit_out = SZ_WORD;
                tgt_addr = {raw[ADDR_W-1:2], 2'b00};
                bus_pos  = alias_off[6:2];
            end
        endcase
    end

endmodule

// File: rtl/bitband_bit_merge.sv
module bitband_bit_merge
    import bitband_pkg::*;
(
    input  logic [DATA_W-1:0] rword,
    input  logic [POS_W-1:0]  pos,
    input  logic              newval,
    output logic              rbit,
    output logic [DATA_W-1:0] mword
);
    always_comb begin
        rbit       = rword[pos];
        mword      = rword;
        mword[pos] = newval;
    end

endmodule

// File: rtl/bitband_seq.sv
module bitband_seq
    import bitband_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_req,
    input  logic              s_we,
    input  logic              s_wbit,
    input  unit_e             map_unit,
    input  logic [ADDR_W-1:0] map_addr,
    input  logic [POS_W-1:0]  map_pos,
    input  logic              m_ready,
    input  logic              m_err,
    input  logic [DATA_W-1:0] merged,
    input  logic              rbit_sel,
    output logic              s_ready,
    output logic [DATA_W-1:0] s_rdata,
    output logic              s_err,
    output logic              m_req,
    output logic              m_we,
    output logic              m_lock,
    output logic [1:0]        m_size,
    output logic [ADDR_W-1:0] m_addr,
    output logic [DATA_W-1:0] m_wdata,
    output logic [POS_W-1:0]  cur_pos,
    output logic              cur_val
);
    seq_regs_t q, d;

    always_comb begin
        d = q;
        unique case (q.st)
            ST_IDLE: begin
                if (s_req) begin
                    d.st    = ST_RD;
                    d.we    = s_we;
                    d.val   = s_wbit;
                    d.unit  = map_unit;
                    d.addr  = map_addr;
                    d.pos   = map_pos;
                    d.rbit  = 1'b0;
                    d.err   = 1'b0;
                end
            end
            ST_RD: begin
                if (m_ready) begin
                    if (m_err) begin
                        d.err  = 1'b1;
                        d.rbit = 1'b0;
                        d.st   = ST_RSP;
                    end else if (q.we) begin
                        d.wword = merged;
                        d.st    = ST_WR;
                    end else begin
                        d.rbit = rbit_sel;
                        d.st   = ST_RSP;
                    end
                end
            end
            ST_WR: begin
                if (m_ready) begin
                    d.err = m_err;
                    d.st  = ST_RSP;
                end
            end
            default: begin
                d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st    <= ST_IDLE;
            q.we    <= 1'b0;
            q.val   <= 1'b0;
            q.unit  <= SZ_BYTE;
            q.addr  <= '0;
            q.pos   <= '0;
            q.wword <= '0;
            q.rbit  <= 1'b0;
            q.err   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        m_req   = (q.st == ST_RD) || (q.st == ST_WR);
        m_we    = (q.st == ST_WR);
        m_lock  = q.we && m_req;
        m_size  = q.unit;
        m_addr  = q.addr;
        m_wdata = q.wword;
        s_ready = (q.st == ST_RSP);
        s_rdata = {{(DATA_W-1){1'b0}}, q.rbit};
        s_err   = q.err;
        cur_pos = q.pos;
        cur_val = q.val;
    end

endmodule

// File: rtl/bitband_bridge.sv
module bitband_bridge
    import bitband_pkg::*;
#(
    parameter logic [31:0] TGT_BASE   = 32'h2000_0000,
    parameter int          ALIAS_BITS = 25
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        s_req,
    input  logic        s_we,
    input  logic [1:0]  s_size,
    input  logic [31:0] s_addr,
    input  logic [31:0] s_wdata,
    output logic        s_ready,
    output logic [31:0] s_rdata,
    output logic        s_err,
    output logic        m_req,
    output logic        m_we,
    output logic        m_lock,
    output logic [1:0]  m_size,
    output logic [31:0] m_addr,
    output logic [31:0] m_wdata,
    input  logic        m_ready,
    input  logic [31:0] m_rdata,
    input  logic        m_err
);
    unit_e              map_unit;
    logic [ADDR_W-1:0]  map_addr;
    logic [POS_W-1:0]   map_pos;
    logic [POS_W-1:0]   cur_pos;
    logic               cur_val;
    logic [DATA_W-1:0]  merged;
    logic               rbit_sel;
    logic               unused_inputs;

    assign unused_inputs = ^{s_addr[31:ALIAS_BITS], s_addr[1:0], s_wdata[31:1]};

    bitband_addr_map #(
        .TGT_BASE   (TGT_BASE),
        .ALIAS_BITS (ALIAS_BITS)
    ) u_map (
        .alias_off (s_addr[ALIAS_BITS-1:2]),
        .size_in   (s_size),
        .unit_out  (map_unit),
        .tgt_addr  (map_addr),
        .bus_pos   (map_pos)
    );

    bitband_bit_merge u_merge (
        .rword  (m_rdata),
        .pos    (cur_pos),
        .newval (cur_val),
        .rbit   (rbit_sel),
        .mword  (merged)
    );

    bitband_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .s_req    (s_req),
        .s_we     (s_we),
        .s_wbit   (s_wdata[0]),
        .map_unit (map_unit),
        .map_addr (map_addr),
        .map_pos  (map_pos),
        .m_ready  (m_ready),
        .m_err    (m_err),
        .merged   (merged),
        .rbit_sel (rbit_sel),
        .s_ready  (s_ready),
        .s_rdata  (s_rdata),
        .s_err    (s_err),
        .m_req    (m_req),
        .m_we     (m_we),
        .m_lock   (m_lock),
        .m_size   (m_size),
        .m_addr   (m_addr),
        .m_wdata  (m_wdata),
        .cur_pos  (cur_pos),
        .cur_val  (cur_val)
    );

endmodule

// File: rtl/bitband_bridge_chk.sv
module bitband_bridge_chk #(
    parameter logic [31:0] TGT_BASE   = 32'h2000_0000,
    parameter int          ALIAS_BITS = 25
) (
    input logic        clk,
    input logic        rst_n,
    input logic        s_req,
    input logic        s_we,
    input logic        s_ready,
    input logic [31:0] s_rdata,
    input logic        m_req,
    input logic        m_we,
    input logic        m_lock,
    input logic [1:0]  m_size,
    input logic [31:0] m_addr,
    input logic [31:0] m_wdata,
    input logic        m_ready,
    input logic        m_err
);
    localparam int SPAN = ALIAS_BITS - 5;

    logic busy_q;
    logic we_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            we_q   <= 1'b0;
        end else if (s_ready) begin
            busy_q <= 1'b0;
        end else if (s_req && !busy_q) begin
            busy_q <= 1'b1;
            we_q   <= s_we;
        end
    end

    // R7
    ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |=> !s_ready);

    // R7
    master_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && !m_ready) |=> (m_req && $stable(m_addr) && $stable(m_we) && $stable(m_wdata)));

    // R4
    rdata_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |-> (s_rdata[31:1] == 31'd0));

    // R8
    no_writeback_after_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && m_ready && m_err && !m_we) |=> !m_req);

    // R6
    locked_writeback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && m_ready && !m_we && !m_err && we_q) |=>
            (m_req && m_we && m_lock && (m_addr == $past(m_addr))));

    // R1
    target_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_req |-> ((m_addr >> SPAN) == (TGT_BASE >> SPAN)));

    // R2
    unit_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_req |-> ((m_size == 2'd2) ? (m_addr[1:0] == 2'b00) :
                   (m_size == 2'd1) ? (m_addr[0] == 1'b0) : (m_size == 2'd0)));

    // R9
    idle_no_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q |-> !m_req);

endmodule

bind bitband_bridge bitband_bridge_chk #(
    .TGT_BASE   (TGT_BASE),
    .ALIAS_BITS (ALIAS_BITS)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .s_req   (s_req),
    .s_we    (s_we),
    .s_ready (s_ready),
    .s_rdata (s_rdata),
    .m_req   (m_req),
    .m_we    (m_we),
    .m_lock  (m_lock),
    .m_size  (m_size),
    .m_addr  (m_addr),
    .m_wdata (m_wdata),
    .m_ready (m_ready),
    .m_err   (m_err)
);

// File: tb/test_bitband_bridge.sv
module tb_target_mem (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        m_req,
    input  logic        m_we,
    input  logic [1:0]  m_size,
    input  logic [31:0] m_addr,
    input  logic [31:0] m_wdata,
    output logic        m_ready,
    output logic [31:0] m_rdata,
    output logic        m_err,
    input  int          lat,
    input  logic        err_en,
    input  logic        err_we,
    input  logic [19:0] err_off
);
    logic [31:0] mem [logic [31:0]];
    int          cnt;
    logic [31:0] wa, cur, lm;
    logic        bad;

    function automatic logic [31:0] seed(logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ 32'h5A5A_1234;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ready <= 1'b0;
            m_err   <= 1'b0;
            m_rdata <= '0;
            cnt     <= 0;
        end else if (m_ready) begin
            m_ready <= 1'b0;
            cnt     <= 0;
        end else if (m_req) begin
            if (cnt >= lat) begin
                wa  = {m_addr[31:2], 2'b00};
                cur = mem.exists(wa) ? mem[wa] : seed(wa);
                bad = err_en && (err_we == m_we) && (m_addr[19:2] == err_off[19:2]);
                case (m_size)
                    2'd0:    lm = 32'hFF << (8 * m_addr[1:0]);
                    2'd1:    lm = 32'hFFFF << (16 * m_addr[1]);
                    default: lm = 32'hFFFF_FFFF;
                endcase
                m_ready <= 1'b1;
                m_err   <= bad;
                m_rdata <= bad ? 32'hDEAD_BEEF : cur;
                if (m_we && !bad) mem[wa] = (cur & ~lm) | (m_wdata & lm);
            end else begin
                cnt <= cnt + 1;
            end
        end
    end
endmodule

module test_bitband_bridge;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] BASES [2] = '{32'h2000_0000, 32'h4000_0000};

    typedef struct {
        logic [31:0] rdata;
        logic        err;
        logic        wr;
        logic [31:0] waddr;
        logic [31:0] wword;
        logic [31:0] wmask;
        string       tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic s_req = 1'b0, s_we = 1'b0;
    logic [1:0]  s_size = 2'd0;
    logic [31:0] s_addr = '0, s_wdata = '0;
    int   lat = 0;
    logic err_en = 1'b0, err_we = 1'b0;
    logic [19:0] err_off = '0;

    logic        s_ready [2];
    logic [31:0] s_rdata [2];
    logic        s_err   [2];
    logic        m_req   [2];
    logic        m_we    [2];
    logic        m_lock  [2];
    logic [1:0]  m_size  [2];
    logic [31:0] m_addr  [2];
    logic [31:0] m_wdata [2];
    logic        m_ready [2];
    logic [31:0] m_rdata [2];
    logic        m_err   [2];

    exp_t        exp_q [2][$];
    logic [31:0] shadow [logic [31:0]];
    int          ph_cnt [2];
    logic        wr_seen [2];
    int          checks = 0, failures = 0;
    bit          done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
        end
    endtask

    function automatic logic [31:0] seed(logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ 32'h5A5A_1234;
    endfunction

    function automatic exp_t model(int i, bit we, logic [1:0] sz, logic [31:0] a, bit v, string tag);
        exp_t e;
        logic [31:0] off, raw, ta, wa, word, nw;
        int pos, lane;
        bit bad_r, bad_w;
        off = a & 32'h01FF_FFFF;
        raw = BASES[i] | (off >> 5);
        if (sz == 2'd0) begin
            ta = raw; lane = int'(raw[1:0]);
            pos = 8 * lane + int'(off[4:2]);
            e.wmask = 32'hFF << (8 * lane);
        end else if (sz == 2'd1) begin
            ta = raw & ~32'd1; lane = int'(raw[1]);
            pos = 16 * lane + int'(off[5:2]);
            e.wmask = 32'hFFFF << (16 * lane);
        end else begin
            ta = raw & ~32'd3;
            pos = int'(off[6:2]);
            e.wmask = 32'hFFFF_FFFF;
        end
        wa = ta & ~32'd3;
        word = shadow.exists(wa) ? shadow[wa] : seed(wa);
        bad_r = err_en && !err_we && (ta[19:2] == err_off[19:2]);
        bad_w = err_en &&  err_we && (ta[19:2] == err_off[19:2]);
        e.rdata = '0; e.err = 1'b0; e.wr = 1'b0; e.waddr = ta; e.wword = word; e.tag = tag;
        if (bad_r) begin
            e.err = 1'b1;
        end else if (we) begin
            nw = word; nw[pos] = v;
            e.wr = 1'b1; e.wword = nw;
            if (bad_w) e.err = 1'b1;
            else shadow[wa] = nw;
        end else begin
            e.rdata = {31'd0, word[pos]};
        end
        return e;
    endfunction

    for (genvar gi = 0; gi < 2; gi++) begin : g_inst
        bitband_bridge #(.TGT_BASE(BASES[gi]), .ALIAS_BITS(25)) i_bitband_bridge (
            .clk(clk), .rst_n(rst_n),
            .s_req(s_req), .s_we(s_we), .s_size(s_size), .s_addr(s_addr), .s_wdata(s_wdata),
            .s_ready(s_ready[gi]), .s_rdata(s_rdata[gi]), .s_err(s_err[gi]),
            .m_req(m_req[gi]), .m_we(m_we[gi]), .m_lock(m_lock[gi]), .m_size(m_size[gi]),
            .m_addr(m_addr[gi]), .m_wdata(m_wdata[gi]),
            .m_ready(m_ready[gi]), .m_rdata(m_rdata[gi]), .m_err(m_err[gi])
        );

        tb_target_mem u_mem (
            .clk(clk), .rst_n(rst_n),
            .m_req(m_req[gi]), .m_we(m_we[gi]), .m_size(m_size[gi]), .m_addr(m_addr[gi]),
            .m_wdata(m_wdata[gi]), .m_ready(m_ready[gi]), .m_rdata(m_rdata[gi]), .m_err(m_err[gi]),
            .lat(lat), .err_en(err_en), .err_we(err_we), .err_off(err_off)
        );

        exp_t it;
        always @(negedge clk) begin
            if (rst_n) begin
                if (m_req[gi] && m_ready[gi]) begin
                    ph_cnt[gi]++;
                    if (m_we[gi]) begin
                        wr_seen[gi] = 1'b1;
                        if (exp_q[gi].size() > 0) begin
                            it = exp_q[gi][0];
                            chk(m_lock[gi], "R6", {it.tag, " lock on write-back"}, {31'd0, m_lock[gi]}, 32'd1);
                            chk(m_addr[gi] == it.waddr, "R2", {it.tag, " write-back address"}, m_addr[gi], it.waddr);
                            chk((m_wdata[gi] & it.wmask) == (it.wword & it.wmask), "R5",
                                {it.tag, " write-back unit"}, m_wdata[gi] & it.wmask, it.wword & it.wmask);
                        end
                    end
                end
                if (s_ready[gi]) begin
                    if (exp_q[gi].size() == 0) begin
                        chk(1'b0, "R7", "response with no request", 32'd1, 32'd0);
                    end else begin
                        it = exp_q[gi].pop_front();
                        chk(s_rdata[gi] == it.rdata, "R4", {it.tag, " read data"}, s_rdata[gi], it.rdata);
                        chk(s_err[gi] == it.err, "R8", {it.tag, " error flag"}, {31'd0, s_err[gi]}, {31'd0, it.err});
                        chk(wr_seen[gi] == it.wr, "R5", {it.tag, " write-back issued"}, {31'd0, wr_seen[gi]}, {31'd0, it.wr});
                        chk(ph_cnt[gi] == (it.wr ? 2 : 1), "R6", {it.tag, " master phase count"},
                            ph_cnt[gi], it.wr ? 32'd2 : 32'd1);
                    end
                    ph_cnt[gi]  = 0;
                    wr_seen[gi] = 1'b0;
                end
            end
        end
    end

    task automatic acc(string tag, bit we, logic [1:0] sz, logic [31:0] a, logic [31:0] wd);
        for (int i = 0; i < 2; i++) exp_q[i].push_back(model(i, we, sz, a, wd[0], tag));
        s_req = 1'b1; s_we = we; s_size = sz; s_addr = a; s_wdata = wd;
        do @(negedge clk); while (!s_ready[0]);
        s_req = 1'b0;
        @(negedge clk);
        chk(!s_ready[0] && !s_ready[1], "R7", {tag, " ready pulse width"}, {31'd0, s_ready[0]}, 32'd0);
    endtask

    initial begin
        for (int i = 0; i < 2; i++) begin ph_cnt[i] = 0; wr_seen[i] = 1'b0; end
        repeat (3) @(negedge clk);
        for (int i = 0; i < 2; i++) begin
            chk(!s_ready[i] && !m_req[i] && !m_lock[i], "R9", "reset outputs",
                {29'd0, s_ready[i], m_req[i], m_lock[i]}, 32'd0);
        end
        rst_n = 1'b1;
        @(negedge clk);

        acc("R4 byte read", 1'b0, 2'd0, 32'h2200_0014, 32'd0);
        acc("R3 byte lane 3", 1'b0, 2'd0, 32'h2200_0068, 32'd0);
        acc("R3 half upper lane", 1'b0, 2'd1, 32'h2200_0074, 32'd0);
        acc("R2 word bit 31", 1'b0, 2'd2, 32'h2200_00FC, 32'd0);
        acc("R2 size code 3", 1'b0, 2'd3, 32'h2200_00B8, 32'd0);
        acc("R5 byte set", 1'b1, 2'd0, 32'h2200_0444, 32'hFFFF_FFFF);
        acc("R5 byte readback", 1'b0, 2'd0, 32'h2200_0444, 32'd0);
        acc("R5 half clear", 1'b1, 2'd1, 32'h2200_0530, 32'hFFFF_FFFE);
        acc("R5 half readback", 1'b0, 2'd1, 32'h2200_0530, 32'd0);
        acc("R5 word set", 1'b1, 2'd2, 32'h2200_06FC, 32'h0000_0001);
        acc("R1 top of window write", 1'b1, 2'd0, 32'h23FF_FFFC, 32'h0000_0001);
        acc("R1 top of window read", 1'b0, 2'd0, 32'h03FF_FFFC, 32'd0);
        acc("R1 upper alias bits", 1'b0, 2'd1, 32'hFE00_0530, 32'd0);
        acc("R1 low alias bits", 1'b0, 2'd0, 32'h2200_0447, 32'd0);

        lat = 3;
        acc("R6 slow write", 1'b1, 2'd2, 32'h2200_0800, 32'h0000_0000);
        acc("R6 slow readback", 1'b0, 2'd2, 32'h2200_0800, 32'd0);

        lat = 1;
        err_en = 1'b1; err_we = 1'b0; err_off = 20'h00100;
        acc("R8 read-phase fail on read", 1'b0, 2'd0, 32'h2200_2000, 32'd0);
        acc("R8 read-phase fail on write", 1'b1, 2'd0, 32'h2200_2004, 32'd1);
        err_we = 1'b1;
        acc("R8 write-phase fail", 1'b1, 2'd2, 32'h2200_2008, 32'h0000_0001);
        err_en = 1'b0;
        acc("R8 unchanged after fail", 1'b0, 2'd2, 32'h2200_2008, 32'd0);
        acc("R8 unchanged byte", 1'b0, 2'd0, 32'h2200_2004, 32'd0);

        for (int k = 0; k < 24; k++) begin
            logic [31:0] a;
            lat = k % 3;
            a = 32'h2200_1000 + 32'(k * 37 * 4);
            acc("R5 walk write", 1'b1, 2'(k % 3), a, 32'(k & 1));
            acc("R3 walk readback", 1'b0, 2'(k % 3), a, 32'd0);
        end

        repeat (4) @(negedge clk);
        for (int i = 0; i < 2; i++)
            chk(exp_q[i].size() == 0, "R7", "pending responses at end", exp_q[i].size(), 32'd0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL R7 watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule